// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control plane of a multi-channel DMA layer. It sits on a simple register bus with an address, write data, write strobe, read strobe and read data. It holds a global configuration word, an error status word, an interrupt enable field and sticky per-channel status words. It also holds one descriptor pointer per transmit channel, and one descriptor pointer plus one buffer size per receive channel. Separate parameters set the transmit and receive channel counts, and each pointer window grows with its own count.

The data-moving engine reports events on pulse inputs. Each pulse sets a sticky bit, and software clears that bit by writing a one to it. Four interrupt lines each combine one status group with its enable bit. A configuration write with the top bit set clears the control and status state in place. The same write then loads the configuration word. The pointer and buffer-size storage survives this soft reset.

Top module: `dma_chan_regbank`

## Requirements
- R1: After power-on reset the configuration register reads 0x0007C000, and the error status, interrupt enable, active and status registers all read zero.
- R2: Every write to the configuration register (0x180) stores the written value ANDed with 0x00FFC087.
- R3: A configuration write with bit 31 set first clears the error status, interrupt enable, TX/RX active and TX/RX end-of-buffer and descriptor-error registers, and it drops any event pulses arriving in that cycle. The configuration register then holds the written value ANDed with 0x00FFC087.
- R4: The error status (0x181), TX end-of-buffer (0x186), TX descriptor-error (0x187), RX end-of-buffer (0x192) and RX descriptor-error (0x193) registers clear each bit written as 1 and keep each bit written as 0. An event pulse in the same cycle wins over the clear.
- R5: A one-cycle pulse on bit i of an event input sets bit i of the matching status register, and the bit stays set.
- R6: TX descriptor pointer i is at 0x1A0+i for i below TX_CH, and RX descriptor pointer i is at 0x1C0+i for i below RX_CH. Both store all 32 bits.
- R7: RX buffer size i is at 0x1E0+i for i below RX_CH. It stores the low 8 bits, and bits 31:8 read as zero.
- R8: A read of any unmapped address returns zero. This includes pointer and size addresses at or beyond the channel count. Writes to such addresses change no register.
- R9: Neither soft reset nor power-on reset changes the pointer or buffer-size registers.
- R10: Read data appears on the clock edge that samples the read strobe, and it holds until the next read.
- R11: irq[0] is enable bit 0 AND (any error status bit). irq[1] is enable bit 1 AND (any TX end-of-buffer bit). irq[2] is enable bit 2 AND (any RX end-of-buffer bit). irq[3] is enable bit 3 AND (any TX or RX descriptor-error bit).
- R12: The interrupt enable register at 0x182 keeps bits 3:0. The TX active register at 0x184 keeps bits TX_CH-1:0, and the RX active register at 0x190 keeps bits RX_CH-1:0. All three are plain read/write registers, and their other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register address |
| wdata | input | 32 | Write data |
| tx_eob_evt | input | TX_CH | TX end-of-buffer event pulses |
| tx_derr_evt | input | TX_CH | TX descriptor-error event pulses |
| rx_eob_evt | input | RX_CH | RX end-of-buffer event pulses |
| rx_derr_evt | input | RX_CH | RX descriptor-error event pulses |
| err_evt | input | ERR_W | Error status event pulses |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Interrupt requests |

## Verification
On every cycle the assertions check four things: the masked store of each configuration write, the clearing effect of a soft reset, the keep-zeros/clear-ones rule on the RX descriptor-error word, and that read data holds between reads. They also check that unmapped and buffer-size reads return the right zero bits, and that an interrupt rises only with its enable set. The bench's scenarios are needed for the rest. They show the exact pointer values surviving a soft reset, an event beating a clear in the same cycle, out-of-range writes leaving neighbours untouched, and the grouping of the four interrupt lines.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int A_CFG    = 'h180;
  localparam int A_ESR    = 'h181;
  localparam int A_IEN    = 'h182;
  localparam int A_TXACT  = 'h184;
  localparam int A_TXEOB  = 'h186;
  localparam int A_TXDERR = 'h187;
  localparam int A_RXACT  = 'h190;
  localparam int A_RXEOB  = 'h192;
  localparam int A_RXDERR = 'h193;
  localparam int A_TXPTR  = 'h1A0;
  localparam int A_RXPTR  = 'h1C0;
  localparam int A_RXSIZE = 'h1E0;

  localparam logic [31:0] CFG_RST  = 32'h0007_C000;
  localparam logic [31:0] CFG_KEEP = 32'h00FF_C087;
  localparam int          SRST_BIT = 31;
  localparam int          MAX_CH   = 32;

  function automatic logic [31:0] cfg_store(input logic [31:0] w);
    return w & CFG_KEEP;
  endfunction

  function automatic logic in_window(input int a, input int base, input int n);
    return (a >= base) && (a < base + n);
  endfunction
endpackage

// File: rtl/dmacr_stat_reg.sv
module dmacr_stat_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] clr,
                                               input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_rst) q <= '0;
    else               q <= sticky_next(q, clr_eff, set_bits);
  end
endmodule

// File: rtl/dmacr_ptr_bank.sv
module dmacr_ptr_bank #(
  parameter int N    = 4,
  parameter int AW   = 10,
  parameter int BASE = 'h1A0,
  parameter int KW   = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [KW-1:0] wdata,
  output logic          hit,
  output logic [31:0]   rval
);
  import dmacr_pkg::*;

  logic [KW-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && int'(addr) == BASE + g) slot[g] <= wdata;
    end
  end

  assign hit = in_window(int'(addr), BASE, N);

  always_comb begin
    rval = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(addr) == BASE + i) rval = 32'(slot[i]);
    end
  end
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank #(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2,
  parameter int ERR_W = 8,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  input  logic [TX_CH-1:0] tx_eob_evt,
  input  logic [TX_CH-1:0] tx_derr_evt,
  input  logic [RX_CH-1:0] rx_eob_evt,
  input  logic [RX_CH-1:0] rx_derr_evt,
  input  logic [ERR_W-1:0] err_evt,
  output logic [31:0]      rdata,
  output logic [3:0]       irq
);
  import dmacr_pkg::*;

  localparam int IEN_W = 4;
  localparam int SIZE_W = 8;

  function automatic logic wsel(input logic en, input logic [AW-1:0] a, input int target);
    return en && (int'(a) == target);
  endfunction

  // named internal events
  logic wr_cfg, soft_rst;
  logic wr_ien, wr_txact, wr_rxact;
  logic wr_esr, wr_txeob, wr_txderr, wr_rxeob, wr_rxderr;
  logic [3:0] grp_any;

  assign wr_cfg    = wsel(wr_en, addr, A_CFG);
  assign soft_rst  = wr_cfg && wdata[SRST_BIT];
  assign wr_ien    = wsel(wr_en, addr, A_IEN);
  assign wr_txact  = wsel(wr_en, addr, A_TXACT);
  assign wr_rxact  = wsel(wr_en, addr, A_RXACT);
  assign wr_esr    = wsel(wr_en, addr, A_ESR);
  assign wr_txeob  = wsel(wr_en, addr, A_TXEOB);
  assign wr_txderr = wsel(wr_en, addr, A_TXDERR);
  assign wr_rxeob  = wsel(wr_en, addr, A_RXEOB);
  assign wr_rxderr = wsel(wr_en, addr, A_RXDERR);

  logic [31:0]      cfg_q;
  logic [IEN_W-1:0] ien_q;
  logic [TX_CH-1:0] txact_q;
  logic [RX_CH-1:0] rxact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (wr_cfg) cfg_q <= cfg_store(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      txact_q <= '0;
      rxact_q <= '0;
    end else if (soft_rst) begin
      ien_q   <= '0;
      txact_q <= '0;
      rxact_q <= '0;
    end else begin
      if (wr_ien)   ien_q   <= wdata[IEN_W-1:0];
      if (wr_txact) txact_q <= wdata[TX_CH-1:0];
      if (wr_rxact) rxact_q <= wdata[RX_CH-1:0];
    end
  end

  // sticky status words
  logic [ERR_W-1:0] esr_q;
  logic [TX_CH-1:0] txeob_q, txderr_q;
  logic [RX_CH-1:0] rxeob_q, rxderr_q;

  dmacr_stat_reg #(.W(ERR_W)) u_esr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_we(wr_esr),
    .clr_bits(wdata[ERR_W-1:0]), .set_bits(err_evt), .q(esr_q));
  dmacr_stat_reg #(.W(TX_CH)) u_txeob (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_we(wr_txeob),
    .clr_bits(wdata[TX_CH-1:0]), .set_bits(tx_eob_evt), .q(txeob_q));
  dmacr_stat_reg #(.W(TX_CH)) u_txderr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_we(wr_txderr),
    .clr_bits(wdata[TX_CH-1:0]), .set_bits(tx_derr_evt), .q(txderr_q));
  dmacr_stat_reg #(.W(RX_CH)) u_rxeob (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_we(wr_rxeob),
    .clr_bits(wdata[RX_CH-1:0]), .set_bits(rx_eob_evt), .q(rxeob_q));
  dmacr_stat_reg #(.W(RX_CH)) u_rxderr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_we(wr_rxderr),
    .clr_bits(wdata[RX_CH-1:0]), .set_bits(rx_derr_evt), .q(rxderr_q));

  // pointer and size windows
  logic        txp_hit, rxp_hit, rxs_hit;
  logic [31:0] txp_val, rxp_val, rxs_val;

  dmacr_ptr_bank #(.N(TX_CH), .AW(AW), .BASE(A_TXPTR), .KW(32)) u_txptr (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(txp_hit), .rval(txp_val));
  dmacr_ptr_bank #(.N(RX_CH), .AW(AW), .BASE(A_RXPTR), .KW(32)) u_rxptr (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(rxp_hit), .rval(rxp_val));
  dmacr_ptr_bank #(.N(RX_CH), .AW(AW), .BASE(A_RXSIZE), .KW(SIZE_W)) u_rxsize (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wdata(wdata[SIZE_W-1:0]),
    .hit(rxs_hit), .rval(rxs_val));

  // read path
  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    case (int'(addr))
      A_CFG:    rmux = cfg_q;
      A_ESR:    rmux = 32'(esr_q);
      A_IEN:    rmux = 32'(ien_q);
      A_TXACT:  rmux = 32'(txact_q);
      A_TXEOB:  rmux = 32'(txeob_q);
      A_TXDERR: rmux = 32'(txderr_q);
      A_RXACT:  rmux = 32'(rxact_q);
      A_RXEOB:  rmux = 32'(rxeob_q);
      A_RXDERR: rmux = 32'(rxderr_q);
      default:  rmux = '0;
    endcase
    if (txp_hit) rmux = txp_val;
    if (rxp_hit) rmux = rxp_val;
    if (rxs_hit) rmux = rxs_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end

  // interrupt grouping
  assign grp_any[0] = |esr_q;
  assign grp_any[1] = |txeob_q;
  assign grp_any[2] = |rxeob_q;
  assign grp_any[3] = (|txderr_q) | (|rxderr_q);
  assign irq = grp_any & ien_q;
endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2,
  parameter int ERR_W = 8,
  parameter int AW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [3:0]       irq,
  input logic [31:0]      cfg_q,
  input logic [3:0]       ien_q,
  input logic             soft_rst,
  input logic [ERR_W-1:0] esr_q,
  input logic [TX_CH-1:0] txeob_q,
  input logic [RX_CH-1:0] rxderr_q,
  input logic [RX_CH-1:0] rx_derr_evt
);
  function automatic logic mapped(input int a);
    if (a >= 'h180 && a <= 'h182) return 1'b1;
    if (a == 'h184 || a == 'h186 || a == 'h187) return 1'b1;
    if (a == 'h190 || a == 'h192 || a == 'h193) return 1'b1;
    if (a >= 'h1A0 && a < 'h1A0 + TX_CH) return 1'b1;
    if (a >= 'h1C0 && a < 'h1C0 + RX_CH) return 1'b1;
    if (a >= 'h1E0 && a < 'h1E0 + RX_CH) return 1'b1;
    return 1'b0;
  endfunction

  a_r2_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 'h180) |=> cfg_q == ($past(wdata) & 32'h00FF_C087));

  a_r3_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ien_q == '0 && esr_q == '0 && txeob_q == '0 && rxderr_q == '0));

  a_r4_w1c_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 'h193 && rx_derr_evt == '0)
      |=> rxderr_q == ($past(rxderr_q) & ~$past(wdata[RX_CH-1:0])));

  a_r7_size_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) >= 'h1E0 && int'(addr) < 'h1E0 + RX_CH) |=> rdata[31:8] == '0);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped(int'(addr))) |=> rdata == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r11_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[1]) |-> ien_q[1]);
endmodule

bind dma_chan_regbank dmacr_chk #(.TX_CH(TX_CH), .RX_CH(RX_CH), .ERR_W(ERR_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .cfg_q(cfg_q), .ien_q(ien_q),
  .soft_rst(soft_rst), .esr_q(esr_q), .txeob_q(txeob_q), .rxderr_q(rxderr_q),
  .rx_derr_evt(rx_derr_evt));

// File: tb/dma_chan_regbank_tb.sv
module dma_chan_regbank_tb;
  localparam int TXN = 4;
  localparam int RXN = 2;
  localparam int EW  = 8;
  localparam int AW  = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [TXN-1:0] tx_eob_evt = '0, tx_derr_evt = '0;
  logic [RXN-1:0] rx_eob_evt = '0, rx_derr_evt = '0;
  logic [EW-1:0]  err_evt = '0;
  logic [31:0]    rdata;
  logic [3:0]     irq;

  dma_chan_regbank #(.TX_CH(TXN), .RX_CH(RXN), .ERR_W(EW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt),
    .rx_eob_evt(rx_eob_evt), .rx_derr_evt(rx_derr_evt), .err_evt(err_evt),
    .rdata(rdata), .irq(irq));

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  function automatic logic [31:0] keep_cfg(input logic [31:0] v);
    logic [31:0] m;
    m = 32'h0;
    m[23:14] = '1;   // bits 23..14
    m[7]     = 1'b1;
    m[2:0]   = '1;
    return v & m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // monitor: read data is valid after the edge that sampled rd_en
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rdata, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic evt(input logic [TXN-1:0] te, input logic [TXN-1:0] td,
                     input logic [RXN-1:0] re, input logic [RXN-1:0] rdv,
                     input logic [EW-1:0] ee);
    @(negedge clk);
    tx_eob_evt = te; tx_derr_evt = td; rx_eob_evt = re; rx_derr_evt = rdv; err_evt = ee;
    @(negedge clk);
    tx_eob_evt = '0; tx_derr_evt = '0; rx_eob_evt = '0; rx_derr_evt = '0; err_evt = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h180, 32'h0007_C000, "R1 cfg reset");
    rd('h181, 32'h0, "R1 esr reset");
    rd('h182, 32'h0, "R1 ien reset");
    rd('h186, 32'h0, "R1 txeob reset");
    rd('h193, 32'h0, "R1 rxderr reset");
    check("R1 irq reset", 32'(irq), 32'h0);

    // R2 masked store
    wr('h180, 32'h1234_5678);
    rd('h180, keep_cfg(32'h1234_5678), "R2 cfg mask");

    // R12 plain registers
    wr('h182, 32'hFFFF_FFFF);
    rd('h182, 32'h0000_000F, "R12 ien width");
    wr('h184, 32'hFFFF_FFFF);
    rd('h184, 32'h0000_000F, "R12 txact width");
    wr('h190, 32'hFFFF_FFFE);
    rd('h190, 32'h0000_0002, "R12 rxact width");

    // R5 / R11 events and interrupts
    evt(4'b0101, 4'b0, 2'b0, 2'b0, 8'h0);
    rd('h186, 32'h5, "R5 txeob set");
    check("R11 irq tx eob", 32'(irq), 32'h2);
    evt(4'b0, 4'b0, 2'b10, 2'b11, 8'h80);
    rd('h181, 32'h80, "R5 esr set");
    check("R11 irq all groups", 32'(irq), 32'hF);

    // R4 write-one-to-clear
    wr('h186, 32'h1);
    rd('h186, 32'h4, "R4 txeob partial clear");
    wr('h186, 32'h4);
    rd('h186, 32'h0, "R4 txeob full clear");
    check("R11 irq tx eob dropped", 32'(irq), 32'hD);
    wr('h193, 32'h1);
    rd('h193, 32'h2, "R4 rxderr keep zeros");
    // event and clear in the same cycle: event wins
    @(negedge clk);
    wr_en = 1'b1; addr = AW'('h181); wdata = 32'hFF; err_evt = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; err_evt = '0;
    rd('h181, 32'h01, "R4 set beats clear");
    wr('h182, 32'h2);
    check("R11 irq masked", 32'(irq), 32'h0);

    // R6 / R7 pointers and sizes
    for (int i = 0; i < TXN; i++) wr('h1A0 + i, 32'hA000_0000 + 32'(i * 16 + 3));
    for (int i = 0; i < RXN; i++) wr('h1C0 + i, 32'hC0DE_0000 + 32'(i));
    for (int i = 0; i < RXN; i++) wr('h1E0 + i, 32'hABCD_12E0 + 32'(i));
    rd('h1A3, 32'hA000_0033, "R6 tx ptr 3");
    rd('h1C1, 32'hC0DE_0001, "R6 rx ptr 1");
    rd('h1E1, 32'h0000_00E1, "R7 rx size upper zero");

    // R8 unmapped
    wr('h1A0 + TXN, 32'hDEAD_BEEF);
    rd('h1A0 + TXN, 32'h0, "R8 tx ptr beyond count");
    rd('h1A0 + TXN - 1, 32'hA000_0033, "R8 neighbour untouched");
    wr('h1C0 + RXN, 32'h1111_1111);
    rd('h1C0 + RXN, 32'h0, "R8 rx ptr beyond count");
    rd('h183, 32'h0, "R8 gap address");
    rd('h1FF, 32'h0, "R8 top address");

    // R3 / R9 soft reset
    evt(4'b1000, 4'b0010, 2'b01, 2'b01, 8'h04);
    wr('h180, 32'hFFFF_FFFF);
    rd('h180, keep_cfg(32'hFFFF_FFFF), "R3 cfg after soft reset");
    rd('h181, 32'h0, "R3 esr cleared");
    rd('h182, 32'h0, "R3 ien cleared");
    rd('h184, 32'h0, "R3 txact cleared");
    rd('h186, 32'h0, "R3 txeob cleared");
    rd('h187, 32'h0, "R3 txderr cleared");
    rd('h192, 32'h0, "R3 rxeob cleared");
    check("R3 irq after soft reset", 32'(irq), 32'h0);
    // event in the soft-reset cycle is dropped
    @(negedge clk);
    wr_en = 1'b1; addr = AW'('h180); wdata = 32'h8000_0000; rx_eob_evt = 2'b11;
    @(negedge clk);
    wr_en = 1'b0; rx_eob_evt = '0;
    rd('h192, 32'h0, "R3 event dropped");
    rd('h180, 32'h0, "R3 cfg zero load");
    rd('h1A3, 32'hA000_0033, "R9 tx ptr kept");
    rd('h1C0, 32'hC0DE_0000, "R9 rx ptr kept");
    rd('h1E0, 32'h0000_00E0, "R9 rx size kept");

    // R10 hold between reads
    @(negedge clk);
    addr = AW'('h1C1);
    @(negedge clk);
    check("R10 data holds without read", rdata, 32'h0000_00E0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule